// File: doc/BRIEF.md
# Gated Capture Counter Channel

This block is one 16-bit event counter for an incremental position or pulse input. Each clock cycle in which the synchronous count strobe is high and the selected gate condition on the G pin is met, the count moves by one. It wraps either at a programmable preset or at full scale. A capture register takes a snapshot of the count on a selectable edge of the Z or G pin. The snapshot then stays frozen until software releases it.

A compare flag records that the count has been equal to the preset at least once. A calibration mechanism loads the count with the preset when G is high while calibration is armed. It then holds a done indication until software acknowledges it. The Z and G pins are asynchronous. They pass through a two-stage synchronizer before any edge is detected. The acknowledge and clear controls act on their rising edges, which are found against a registered copy of each control bit.

Three state machines make up the control:
- Capture machine: states OPEN and HELD. The TAKE transition goes from OPEN to HELD on a trigger. The RELEASE transition goes from HELD to OPEN on a store-clear edge.
- Calibration machine: states IDLE, ARMED and DONE.
  - ARM goes from IDLE to ARMED when calibration is enabled in gate mode 11.
  - DISARM goes from ARMED to IDLE when that condition drops.
  - FIRE goes from ARMED to DONE when the synchronized G is high. FIRE also loads the preset.
  - REARM goes from DONE to ARMED on an acknowledge edge. RETIRE goes from DONE to IDLE on an acknowledge edge when calibration is no longer enabled.
- Counter operation: chosen each cycle from HOLD, LOAD, UP and DOWN.

Top module: `evt_capture_channel`

## Requirements
- R1: A synchronous active-high `rst` clears `count`, `capture`, `store_flag`, `reached_flag` and `cal_done` to 0.
- R2: `gate_mode` 2'b00 counts every strobed cycle. 2'b01 counts only while the synchronized G is high. 2'b10 counts only while the synchronized G is low.
- R3: With `gate_mode` 2'b11, counting happens only while G is low. While calibration is ARMED, a high G loads `count` with `preset` and moves the machine to DONE.
- R4: `store_sel` picks the capture trigger. 2'b00 is the rising edge of Z. 2'b01 is the rising edge of G. 2'b10 is the falling edge of G. 2'b11 is either edge of G. A trigger copies the current `count` into `capture` and sets `store_flag`.
- R5: While `store_flag` is set, further triggers are ignored and `capture` stays unchanged.
- R6: A rising edge on `store_clr` clears `store_flag`. This clear wins over a trigger that arrives in the same cycle.
- R7: `reached_flag` sets in the cycle after `count` equals `preset` and stays set. A rising edge on `reached_clr` clears it, but only while the count is not at the preset.
- R8: With `wrap_at_preset` = 1, an up-count from the value `preset` goes to 0.
- R9: With `wrap_at_preset` = 0, an up-count from 16'hFFFF goes to 0.
- R10: Calibration takes effect only with `cal_en` = 1. `cal_done` stays set until a rising edge on `cal_ack`. That edge re-arms the machine, and a new calibration can then follow.
- R11: In `gate_mode` 2'b11 with `cal_neg` = 1 the counter counts down. A down-count from 0 goes to the wrap point, which is `preset` or 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pulse | input | 1 | Count strobe, one step per high cycle |
| z_in | input | 1 | Asynchronous reference pin |
| g_in | input | 1 | Asynchronous gate pin |
| gate_mode | input | 2 | Gate qualification mode |
| store_sel | input | 2 | Capture trigger select |
| wrap_at_preset | input | 1 | 1: wrap at preset, 0: wrap at full scale |
| cal_en | input | 1 | Calibration enable |
| cal_neg | input | 1 | Calibration direction, 1 = negative (down-count in mode 11) |
| cal_ack | input | 1 | Rising edge acknowledges calibration and re-arms it |
| store_clr | input | 1 | Rising edge releases the capture |
| reached_clr | input | 1 | Rising edge clears the compare flag |
| preset | input | 16 | Preset for wrap, compare and calibration load |
| count | output | 16 | Live count |
| capture | output | 16 | Captured count |
| store_flag | output | 1 | Capture held |
| reached_flag | output | 1 | Count has equalled the preset |
| cal_done | output | 1 | Calibration finished, awaiting acknowledge |

## Verification
A capture machine stuck in HELD shows up as an unchanged `capture` and a `store_flag` that stays high. This is visible three cycles after the next pin edge, which is how long the synchronizer and edge stage take. A lost or spurious step in the counter is visible on `count` at the very next edge. The bench freezes the strobe before every comparison, so a single miscounted step leaves a permanent offset. A calibration machine in the wrong state either reloads the preset a second time on G, or never reloads it after the acknowledge. Either mistake changes `count` within four cycles of the G or acknowledge change.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        GM_FREE = 2'b00,
        GM_HIGH = 2'b01,
        GM_LOW  = 2'b10,
        GM_CAL  = 2'b11
    } gate_mode_e;

    typedef enum logic [1:0] {
        SS_Z_RISE = 2'b00,
        SS_G_RISE = 2'b01,
        SS_G_FALL = 2'b10,
        SS_G_BOTH = 2'b11
    } store_sel_e;

    typedef enum logic {
        ST_OPEN,
        ST_HELD
    } store_st_e;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_ARMED,
        CAL_DONE
    } cal_st_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_UP,
        OP_DOWN
    } cnt_op_e;

endpackage

// File: rtl/evc_sampler.sv
module evc_sampler #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    generate
        if (STAGES == 0) begin : g_direct
            assign cur_o = d_i;
        end else begin : g_sync
            logic [STAGES-1:0][W-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '0;
                end else begin
                    chain[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end
            assign cur_o = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_o <= '0;
        else     prev_o <= cur_o;
    end

endmodule

// File: rtl/evc_store_unit.sv
module evc_store_unit
    import evc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig_i,
    input  logic         clr_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] capture_o,
    output logic         flag_o
);

    store_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (trig_i && !clr_i) state_d = ST_HELD;  // TAKE
            ST_HELD: if (clr_i)            state_d = ST_OPEN;  // RELEASE
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capture_o <= '0;
        end else if (state_q == ST_OPEN && trig_i && !clr_i) begin
            capture_o <= count_i;
        end
    end

    assign flag_o = (state_q == ST_HELD);

    assert_capture_lock_R5: assert property (@(posedge clk) disable iff (rst)
        flag_o |=> $stable(capture_o));

    assert_store_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag_o);

    assert_capture_take_R4: assert property (@(posedge clk) disable iff (rst)
        (!flag_o && trig_i && !clr_i) |=> (flag_o && capture_o == $past(count_i)));

endmodule

// File: rtl/evc_cal_fsm.sv
module evc_cal_fsm
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_ok_i,
    input  logic g_lvl_i,
    input  logic ack_rise_i,
    output logic load_o,
    output logic done_o
);

    cal_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= CAL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:  if (arm_ok_i) state_d = CAL_ARMED;                   // ARM
            CAL_ARMED: begin
                if (!arm_ok_i)    state_d = CAL_IDLE;                       // DISARM
                else if (g_lvl_i) state_d = CAL_DONE;                       // FIRE
            end
            CAL_DONE:  if (ack_rise_i) state_d = arm_ok_i ? CAL_ARMED       // REARM
                                                          : CAL_IDLE;       // RETIRE
            default:   state_d = CAL_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            CAL_IDLE:  ;
            CAL_ARMED: load_o = arm_ok_i && g_lvl_i;
            CAL_DONE:  done_o = 1'b1;
            default:   ;
        endcase
    end

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ack_rise_i) |=> done_o);

    assert_no_cal_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        (!arm_ok_i && !done_o) |=> !done_o);

endmodule

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         down_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] wrap_val_i,
    input  logic [W-1:0] preset_i,
    input  logic         reached_clr_i,
    output logic [W-1:0] count_o,
    output logic         reached_o
);

    cnt_op_e        op;
    logic [W-1:0]   count_d;

    always_comb begin
        if (load_i)       op = OP_LOAD;
        else if (!step_i) op = OP_HOLD;
        else if (down_i)  op = OP_DOWN;
        else              op = OP_UP;
    end

    always_comb begin
        count_d = count_o;
        unique case (op)
            OP_HOLD: count_d = count_o;
            OP_LOAD: count_d = load_val_i;
            OP_UP:   count_d = (count_o == wrap_val_i) ? '0 : count_o + 1'b1;
            OP_DOWN: count_d = (count_o == '0) ? wrap_val_i : count_o - 1'b1;
            default: count_d = count_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_o <= '0;
        else     count_o <= count_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                         reached_o <= 1'b0;
        else if (count_o == preset_i)    reached_o <= 1'b1;
        else if (reached_clr_i)          reached_o <= 1'b0;
    end

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(count_o));

    assert_load_value_R3: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (count_o == $past(load_val_i)));

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && !down_i && count_o == wrap_val_i) |=> (count_o == '0));

    assert_wrap_down_R11: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && down_i && count_o == '0) |=> (count_o == $past(wrap_val_i)));

    assert_reached_set_R7: assert property (@(posedge clk) disable iff (rst)
        (count_o == preset_i) |=> reached_o);

    assert_reached_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (reached_clr_i && count_o != preset_i) |=> !reached_o);

endmodule

// File: rtl/evt_capture_channel.sv
module evt_capture_channel
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_pulse,
    input  logic             z_in,
    input  logic             g_in,
    input  logic [1:0]       gate_mode,
    input  logic [1:0]       store_sel,
    input  logic             wrap_at_preset,
    input  logic             cal_en,
    input  logic             cal_neg,
    input  logic             cal_ack,
    input  logic             store_clr,
    input  logic             reached_clr,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture,
    output logic             store_flag,
    output logic             reached_flag,
    output logic             cal_done
);

    localparam int PIN_N = 2;
    localparam int CTL_N = 3;
    localparam logic [CNT_W-1:0] FULL_SCALE = '1;

    gate_mode_e       gm;
    store_sel_e       ss;
    logic [PIN_N-1:0] pin_cur, pin_prev;
    logic [CTL_N-1:0] ctl_cur, ctl_prev, ctl_rise;
    logic             z_rise, g_lvl, g_rise, g_fall;
    logic             gate_ok, step, trig, cal_load, cal_arm_ok, down;
    logic [CNT_W-1:0] wrap_val;

    assign gm = gate_mode_e'(gate_mode);
    assign ss = store_sel_e'(store_sel);

    evc_sampler #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({g_in, z_in}),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    evc_sampler #(.W(CTL_N), .STAGES(0)) u_ctls (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({cal_ack, reached_clr, store_clr}),
        .cur_o  (ctl_cur),
        .prev_o (ctl_prev)
    );

    assign ctl_rise = ctl_cur & ~ctl_prev;
    assign z_rise   = pin_cur[0] & ~pin_prev[0];
    assign g_lvl    = pin_cur[1];
    assign g_rise   = pin_cur[1] & ~pin_prev[1];
    assign g_fall   = ~pin_cur[1] & pin_prev[1];

    always_comb begin
        unique case (gm)
            GM_FREE: gate_ok = 1'b1;
            GM_HIGH: gate_ok = g_lvl;
            GM_LOW:  gate_ok = ~g_lvl;
            GM_CAL:  gate_ok = ~g_lvl;
            default: gate_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (ss)
            SS_Z_RISE: trig = z_rise;
            SS_G_RISE: trig = g_rise;
            SS_G_FALL: trig = g_fall;
            SS_G_BOTH: trig = g_rise | g_fall;
            default:   trig = 1'b0;
        endcase
    end

    assign step       = cnt_pulse & gate_ok;
    assign down       = (gm == GM_CAL) & cal_neg;
    assign cal_arm_ok = cal_en & (gm == GM_CAL);
    assign wrap_val   = wrap_at_preset ? preset : FULL_SCALE;

    evc_cal_fsm u_cal (
        .clk        (clk),
        .rst        (rst),
        .arm_ok_i   (cal_arm_ok),
        .g_lvl_i    (g_lvl),
        .ack_rise_i (ctl_rise[2]),
        .load_o     (cal_load),
        .done_o     (cal_done)
    );

    evc_counter #(.W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .step_i        (step),
        .down_i        (down),
        .load_i        (cal_load),
        .load_val_i    (preset),
        .wrap_val_i    (wrap_val),
        .preset_i      (preset),
        .reached_clr_i (ctl_rise[1]),
        .count_o       (count),
        .reached_o     (reached_flag)
    );

    evc_store_unit #(.W(CNT_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig),
        .clr_i     (ctl_rise[0]),
        .count_i   (count),
        .capture_o (capture),
        .flag_o    (store_flag)
    );

    assert_gate_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        (!cal_load && ((gm == GM_HIGH && !g_lvl) || (gm == GM_LOW && g_lvl))) |=> $stable(count));

    assert_cal_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (gm == GM_CAL && g_lvl && !cal_load) |=> $stable(count));

endmodule

// File: tb/sim_evt_capture_channel.sv
`timescale 1ns/1ps
module sim_evt_capture_channel;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         cnt_pulse, z_in, g_in, wrap_at_preset, cal_en, cal_neg, cal_ack;
    logic         store_clr, reached_clr;
    logic [1:0]   gate_mode, store_sel;
    logic [W-1:0] preset, count, capture;
    logic         store_flag, reached_flag, cal_done;

    always #2.5 clk = ~clk;

    evt_capture_channel u0 (
        .clk(clk), .rst(rst), .cnt_pulse(cnt_pulse), .z_in(z_in), .g_in(g_in),
        .gate_mode(gate_mode), .store_sel(store_sel), .wrap_at_preset(wrap_at_preset),
        .cal_en(cal_en), .cal_neg(cal_neg), .cal_ack(cal_ack), .store_clr(store_clr),
        .reached_clr(reached_clr), .preset(preset), .count(count), .capture(capture),
        .store_flag(store_flag), .reached_flag(reached_flag), .cal_done(cal_done)
    );

    typedef struct {
        string        rid;
        int           sel;
        logic [W-1:0] exp;
    } item_t;

    item_t q[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;

    // Monitor: pops expected items and compares against the outputs.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t        it;
            logic [W-1:0] act;
            string        nm;
            it = q.pop_front();
            case (it.sel)
                0: begin act = count;                 nm = "count";        end
                1: begin act = capture;               nm = "capture";      end
                2: begin act = {15'd0, store_flag};   nm = "store_flag";   end
                3: begin act = {15'd0, reached_flag}; nm = "reached_flag"; end
                default: begin act = {15'd0, cal_done}; nm = "cal_done";   end
            endcase
            vectors++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s %s actual=%h expected=%h", it.rid, nm, act, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string rid, input int sel, input logic [W-1:0] e);
        item_t it;
        it.rid = rid; it.sel = sel; it.exp = e;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pulse = 1'b1;
            @(negedge clk);
        end
        cnt_pulse = 1'b0;
    endtask

    task automatic pulse_store_clr();
        store_clr = 1'b1; cyc(2); store_clr = 1'b0; cyc(2);
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_pulse = 0; z_in = 0; g_in = 0; wrap_at_preset = 0;
        cal_en = 0; cal_neg = 0; cal_ack = 0; store_clr = 0; reached_clr = 0;
        gate_mode = 2'b00; store_sel = 2'b00; preset = 16'd100;
        cyc(3);
        // R1 reset state
        expect_val("R1", 0, 16'd0);
        expect_val("R1", 1, 16'd0);
        expect_val("R1", 2, 16'd0);
        expect_val("R1", 3, 16'd0);
        expect_val("R1", 4, 16'd0);
        rst = 1'b0; cyc(1);

        // R2 free counting
        pulses(10);
        expect_val("R2", 0, 16'd10);
        // R2 count only while G high
        gate_mode = 2'b01; cyc(4); pulses(5);
        expect_val("R2", 0, 16'd10);
        g_in = 1; cyc(4); pulses(5);
        expect_val("R2", 0, 16'd15);
        // R2 count only while G low
        gate_mode = 2'b10; cyc(4); pulses(3);
        expect_val("R2", 0, 16'd15);
        g_in = 0; cyc(4); pulses(3);
        expect_val("R2", 0, 16'd18);

        // R4 capture on Z rise
        gate_mode = 2'b00; store_sel = 2'b00;
        z_in = 1; cyc(4);
        expect_val("R4", 1, 16'd18);
        expect_val("R4", 2, 16'd1);
        // R5 capture locked while flag set
        pulses(4); z_in = 0; cyc(4); z_in = 1; cyc(4);
        expect_val("R5", 1, 16'd18);
        expect_val("R5", 0, 16'd22);
        // R6 store clear edge
        pulse_store_clr();
        expect_val("R6", 2, 16'd0);

        // R4 capture on G rise
        store_sel = 2'b01; g_in = 1; cyc(4);
        expect_val("R4", 1, 16'd22);
        pulse_store_clr();
        // R4 capture on G fall
        store_sel = 2'b10; pulses(3); g_in = 0; cyc(4);
        expect_val("R4", 1, 16'd25);
        pulse_store_clr();
        // R4 capture on both G edges
        store_sel = 2'b11; pulses(2); g_in = 1; cyc(4);
        expect_val("R4", 1, 16'd27);
        pulse_store_clr();
        pulses(1); g_in = 0; cyc(4);
        expect_val("R4", 1, 16'd28);
        pulse_store_clr();

        // R7 compare flag
        expect_val("R7", 3, 16'd0);
        preset = 16'd30; pulses(2); cyc(2);
        expect_val("R7", 3, 16'd1);
        pulses(3); cyc(2);
        expect_val("R7", 3, 16'd1);
        reached_clr = 1; cyc(2);
        expect_val("R7", 3, 16'd0);
        reached_clr = 0; cyc(1);

        // R8 wrap at preset
        z_in = 0; store_sel = 2'b00; preset = 16'd5; wrap_at_preset = 1;
        do_reset();
        pulses(7);
        expect_val("R8", 0, 16'd1);
        expect_val("R8", 3, 16'd1);

        // R11 down count in mode 11, R9 full-scale wrap
        preset = 16'd100; wrap_at_preset = 0;
        do_reset();
        gate_mode = 2'b11; cal_neg = 1; cyc(4);
        pulses(1);
        expect_val("R11", 0, 16'hFFFF);
        pulses(2);
        expect_val("R11", 0, 16'hFFFD);
        gate_mode = 2'b00; pulses(2);
        expect_val("R9", 0, 16'hFFFF);
        pulses(1);
        expect_val("R9", 0, 16'h0000);

        // R3 / R10 calibration
        gate_mode = 2'b00; cal_neg = 0; preset = 16'h0040;
        do_reset();
        gate_mode = 2'b11; cyc(2); pulses(3);
        expect_val("R3", 0, 16'd3);
        g_in = 1; cyc(4); pulses(3);
        expect_val("R3", 0, 16'd3);
        expect_val("R10", 4, 16'd0);
        cal_en = 1; cyc(4);
        expect_val("R3", 0, 16'h0040);
        expect_val("R10", 4, 16'd1);
        g_in = 0; cyc(4); pulses(2);
        expect_val("R3", 0, 16'h0042);
        g_in = 1; cyc(4);
        expect_val("R10", 0, 16'h0042);
        expect_val("R10", 4, 16'd1);
        cal_ack = 1; cyc(4);
        expect_val("R10", 0, 16'h0040);
        expect_val("R10", 4, 16'd1);
        cal_ack = 0; cyc(2);

        done = 1;
        summary();
        $finish;
    end

endmodule